// File: doc/BRIEF.md
# Freeze Button Sequencer

This block controls the freezer of a cartridge that plugs into an 8-bit home computer. It filters the freeze button and measures how long it is held. A long press followed by a release makes the block request both a maskable and a non-maskable interrupt. It then watches the host bus. The host CPU saves its return address and status on the stack page before it fetches an interrupt vector. When the block sees three back-to-back write cycles into that page, it commits to freeze mode. It raises a flag that the memory-map logic uses to supply the cartridge's own vectors.

The block samples the bus once per bus cycle, on the falling edge of the bus clock phase. That phase input is synchronous to the block clock. The block asserts a tick on the first block-clock edge at which the phase reads low after reading high, and it takes the address and the read/write line at that edge. Button hold time is counted in bus cycles. The count is derived from the bus frequency and the required hold time, both parameters. Freeze mode ends only on reset or when the control register is written with its restore bit set. That bit is bit 6 of the written byte.

Top module: `freeze_sequencer`

## Requirements
- R1: A reset, whenever it occurs, clears the request and freeze state: irqReq, nmiReq and freezeActive are all 0 after it.
- R2: The button must read pressed at more than HOLD_CYC bus-cycle ticks in a row and then read released at a tick. HOLD_CYC = BUS_KHZ*HOLD_US/1000, which is 2 by default. On the clock edge after that release tick, irqReq and nmiReq become 1 together.
- R3: If the button is held for HOLD_CYC ticks or fewer and then released, no request is raised.
- R4: While a request is pending, the third write tick in a row whose address lies in 0x0100 to 0x01FF sets freezeActive. The same edge drops irqReq and nmiReq. A write tick has busRnW = 0.
- R5: While pending, any tick that is not a stack-page write restarts the run. Such a tick is a read, including a read of the stack page, or a write outside the page. Three new consecutive stack writes are then needed.
- R6: Stack-page writes made before the request was raised are not counted. This includes a write at the release tick itself.
- R7: A pending request stays asserted for any number of bus cycles without stack writes, and freezeActive stays 0.
- R8: While freezeActive is 1, the button has no effect: a long press and release raises no request.
- R9: While frozen, a control write whose bit 6 is 0 leaves freezeActive at 1. A control write with bit 6 = 1 clears it on the next edge.
- R10: buttonDown shows the button level two block-clock edges after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| buttonRaw | input | 1 | Freeze button level, 1 = pressed, asynchronous |
| busAddr | input | ADDR_W (16) | Host bus address |
| busRnW | input | 1 | Host bus read/write, 1 = read |
| busPhi2 | input | 1 | Bus clock phase; its falling edge ends a bus cycle |
| regWrite | input | 1 | One-cycle strobe: control register written |
| regData | input | 8 | Byte written to the control register |
| irqReq | output | 1 | Maskable interrupt request, 1 = request |
| nmiReq | output | 1 | Non-maskable interrupt request, 1 = request |
| freezeActive | output | 1 | Freeze memory map in force |
| buttonDown | output | 1 | Synchronized button level |

## Verification
The assertions check, on every cycle, the rules that relate adjacent cycles. A request may only rise after a bus tick with the button released. Freeze mode may only start at a stack-page write tick, and it drops the requests at that moment. Request and freeze are never both set. A pending request only ends in freeze or reset, and freeze holds until a restore write. The hold-time threshold depends on a count over many cycles, and only the bench's scenarios show it. The same holds for the restart of the write run after a break, the ignoring of stack writes made before the request, and the idle wait of indefinite length.

// File: rtl/freeze_pkg.sv
package freeze_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic countEn;  // stack-write run counting allowed (request pending)
    logic btnEn;    // button qualification allowed (not frozen)
  } seqCtl_t;

  // Events from datapath to control
  typedef struct packed {
    logic longRelease; // qualified button release at a bus tick
    logic thirdWrite;  // final stack write of the entry run
  } seqEvt_t;

endpackage

// File: rtl/freeze_datapath.sv
module freeze_datapath
  import freeze_pkg::*;
#(
  parameter int unsigned BUS_KHZ     = 1000,
  parameter int unsigned HOLD_US     = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RUN_LEN     = 3,
  parameter int unsigned ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] PAGE_MASK = 16'hFF00,
  parameter logic [ADDR_W-1:0] PAGE_BASE = 16'h0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              buttonRaw,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRnW,
  input  logic              busPhi2,
  input  seqCtl_t           ctl,
  output seqEvt_t           evt,
  output logic              buttonLevel
);

  localparam int unsigned HOLD_RAW = (BUS_KHZ * HOLD_US) / 1000;
  localparam int unsigned HOLD_CYC = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
  localparam int unsigned HOLD_LIM = HOLD_CYC + 1;
  localparam int unsigned HOLD_W   = $clog2(HOLD_LIM + 1);
  localparam int unsigned RUN_W    = (RUN_LEN < 2) ? 1 : $clog2(RUN_LEN);

  // Button synchronizer chain
  logic [SYNC_STAGES-1:0] syncChain;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) syncChain[0] <= 1'b0;
          else     syncChain[0] <= buttonRaw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) syncChain[i] <= 1'b0;
          else     syncChain[i] <= syncChain[i-1];
        end
      end
    end
  endgenerate

  assign buttonLevel = syncChain[SYNC_STAGES-1];

  // Bus cycle tick: phase seen high, now low
  logic phi2Prev;
  logic busTick;

  always_ff @(posedge clk) begin
    if (rst) phi2Prev <= 1'b0;
    else     phi2Prev <= busPhi2;
  end

  assign busTick = phi2Prev & ~busPhi2;

  // Stack-page write detection and run counter
  logic             isStackWr;
  logic [RUN_W-1:0] runCnt;
  logic             runLast;

  assign isStackWr = ~busRnW & ((busAddr & PAGE_MASK) == PAGE_BASE);
  assign runLast   = (runCnt == RUN_W'(RUN_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst || !ctl.countEn) begin
      runCnt <= '0;
    end else if (busTick) begin
      if (isStackWr && !runLast) runCnt <= runCnt + RUN_W'(1);
      else                       runCnt <= '0;
    end
  end

  // Button hold counter, saturating one past the threshold
  logic [HOLD_W-1:0] holdCnt;
  logic              holdMet;

  assign holdMet = (holdCnt == HOLD_W'(HOLD_LIM));

  always_ff @(posedge clk) begin
    if (rst || !ctl.btnEn) begin
      holdCnt <= '0;
    end else if (busTick) begin
      if (!buttonLevel)  holdCnt <= '0;
      else if (!holdMet) holdCnt <= holdCnt + HOLD_W'(1);
    end
  end

  assign evt.longRelease = busTick & ctl.btnEn & ~buttonLevel & holdMet;
  assign evt.thirdWrite  = busTick & ctl.countEn & isStackWr & runLast;

endmodule

// File: rtl/freeze_control.sv
module freeze_control
  import freeze_pkg::*;
#(
  parameter int unsigned REL_BIT = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  seqEvt_t    evt,
  input  logic       regWrite,
  input  logic [7:0] regData,
  output seqCtl_t    ctl,
  output logic       pending,
  output logic       done
);

  localparam logic [7:0] REL_MASK = 8'(1) << REL_BIT;

  logic releaseHit;
  assign releaseHit = regWrite & ((regData & REL_MASK) != 8'h00);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      done    <= 1'b0;
    end else if (evt.thirdWrite) begin
      pending <= 1'b0;
      done    <= 1'b1;
    end else begin
      if (releaseHit)      done    <= 1'b0;
      if (evt.longRelease) pending <= 1'b1;
    end
  end

  assign ctl.countEn = pending;
  assign ctl.btnEn   = ~done;

endmodule

// File: rtl/freeze_sequencer.sv
module freeze_sequencer
  import freeze_pkg::*;
#(
  parameter int unsigned BUS_KHZ     = 1000,
  parameter int unsigned HOLD_US     = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RUN_LEN     = 3,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned REL_BIT     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              buttonRaw,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRnW,
  input  logic              busPhi2,
  input  logic              regWrite,
  input  logic [7:0]        regData,
  output logic              irqReq,
  output logic              nmiReq,
  output logic              freezeActive,
  output logic              buttonDown
);

  localparam logic [ADDR_W-1:0] PAGE_MASK = {ADDR_W{1'b1}} << 8;
  localparam logic [ADDR_W-1:0] PAGE_BASE = ADDR_W'(16'h0100);

  seqCtl_t ctl;
  seqEvt_t evt;
  logic    pending;
  logic    done;

  freeze_datapath #(
    .BUS_KHZ    (BUS_KHZ),
    .HOLD_US    (HOLD_US),
    .SYNC_STAGES(SYNC_STAGES),
    .RUN_LEN    (RUN_LEN),
    .ADDR_W     (ADDR_W),
    .PAGE_MASK  (PAGE_MASK),
    .PAGE_BASE  (PAGE_BASE)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .buttonRaw  (buttonRaw),
    .busAddr    (busAddr),
    .busRnW     (busRnW),
    .busPhi2    (busPhi2),
    .ctl        (ctl),
    .evt        (evt),
    .buttonLevel(buttonDown)
  );

  freeze_control #(
    .REL_BIT(REL_BIT)
  ) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt),
    .regWrite(regWrite),
    .regData (regData),
    .ctl     (ctl),
    .pending (pending),
    .done    (done)
  );

  assign irqReq       = pending;
  assign nmiReq       = pending;
  assign freezeActive = done;

endmodule

// File: rtl/freeze_sequencer_checker.sv
module freeze_sequencer_checker (
  input logic        clk,
  input logic        rst,
  input logic [15:0] busAddr,
  input logic        busRnW,
  input logic        busPhi2,
  input logic        regWrite,
  input logic [7:0]  regData,
  input logic        irqReq,
  input logic        nmiReq,
  input logic        freezeActive,
  input logic        buttonDown
);

  logic stackWr;
  logic restoreWr;
  assign stackWr   = !busRnW && ((busAddr & 16'hFF00) == 16'h0100);
  assign restoreWr = regWrite && ((regData & 8'h40) != 8'h00);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!irqReq && !nmiReq && !freezeActive));

  p_request_at_release_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(irqReq) |-> ($past(!busPhi2) && $past(busPhi2, 2) && $past(!buttonDown) && $rose(nmiReq)));

  p_freeze_at_stack_write_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(freezeActive) |-> ($past(stackWr) && $past(!busPhi2) && $fell(irqReq) && $fell(nmiReq)));

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
    !(irqReq && freezeActive));

  p_pending_holds_r7: assert property (@(posedge clk) disable iff (rst)
    irqReq |=> (irqReq || freezeActive));

  p_button_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    freezeActive |=> !irqReq);

  p_freeze_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (freezeActive && !restoreWr) |=> freezeActive);

  p_restore_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (freezeActive && restoreWr) |=> !freezeActive);

endmodule

bind freeze_sequencer freeze_sequencer_checker u_chk (.*);

// File: tb/freeze_sequencer_test.sv
`timescale 1ns/1ps
module freeze_sequencer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        buttonRaw = 1'b0;
  logic [15:0] busAddr = 16'h0000;
  logic        busRnW = 1'b1;
  logic        busPhi2 = 1'b0;
  logic        regWrite = 1'b0;
  logic [7:0]  regData = 8'h00;
  logic        irqReq, nmiReq, freezeActive, buttonDown;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  typedef struct {
    string      tag;
    logic [3:0] exp; // {irq, nmi, freeze, button}
  } item_t;

  item_t expQ[$];

  always #2 clk = ~clk; // 250 MHz

  freeze_sequencer uut (
    .clk(clk), .rst(rst), .buttonRaw(buttonRaw), .busAddr(busAddr),
    .busRnW(busRnW), .busPhi2(busPhi2), .regWrite(regWrite), .regData(regData),
    .irqReq(irqReq), .nmiReq(nmiReq), .freezeActive(freezeActive),
    .buttonDown(buttonDown)
  );

  // Monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      item_t it;
      logic [3:0] act;
      it  = expQ.pop_front();
      act = {irqReq, nmiReq, freezeActive, buttonDown};
      compared++;
      if (act !== it.exp) begin
        mismatched++;
        $display("FAIL %s: actual irq/nmi/frz/btn=%b expected=%b", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_state(input string tag, input logic irq, input logic frz, input logic btn);
    item_t it;
    it.tag = tag;
    it.exp = {irq, irq, frz, btn};
    expQ.push_back(it);
  endtask

  // One bus cycle: phase high two clocks, low two clocks; tick on first low edge
  task automatic bus_cycle(input logic [15:0] a, input logic rnw, input logic btn);
    @(negedge clk);
    busAddr = a; busRnW = rnw; buttonRaw = btn; busPhi2 = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    busPhi2 = 1'b0;
    @(posedge clk);
    @(posedge clk);
  endtask

  task automatic long_press(input int n, input logic [15:0] relAddr, input logic relRnW);
    for (int i = 0; i < n; i++) bus_cycle(16'h1000, 1'b1, 1'b1);
    bus_cycle(relAddr, relRnW, 1'b0);
  endtask

  task automatic reg_wr(input logic [7:0] d);
    @(negedge clk);
    regWrite = 1'b1; regData = d;
    @(posedge clk);
    #1 regWrite = 1'b0;
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    expect_state("R1 reset state", 1'b0, 1'b0, 1'b0);

    // R10 and R3: two pressed cycles only
    bus_cycle(16'h1000, 1'b1, 1'b1);
    expect_state("R10 button level", 1'b0, 1'b0, 1'b1);
    bus_cycle(16'h1000, 1'b1, 1'b1);
    bus_cycle(16'h1000, 1'b1, 1'b0);
    expect_state("R3 short press ignored", 1'b0, 1'b0, 1'b0);

    // R2 with a stack write at the release tick (R6)
    long_press(3, 16'h01F0, 1'b0);
    expect_state("R2 long press raises requests", 1'b1, 1'b0, 1'b0);
    bus_cycle(16'h01E0, 1'b0, 1'b0);
    bus_cycle(16'h01D0, 1'b0, 1'b0);
    expect_state("R6 release-tick write not counted", 1'b1, 1'b0, 1'b0);
    bus_cycle(16'h01C0, 1'b0, 1'b0);
    expect_state("R4 third stack write freezes", 1'b0, 1'b1, 1'b0);

    // R8: button ignored while frozen
    long_press(4, 16'h1000, 1'b1);
    expect_state("R8 press ignored in freeze", 1'b0, 1'b1, 1'b0);

    // R9: restore bit
    reg_wr(8'hBF);
    expect_state("R9 write without bit 6 keeps freeze", 1'b0, 1'b1, 1'b0);
    reg_wr(8'h40);
    expect_state("R9 bit 6 restores map", 1'b0, 1'b0, 1'b0);

    // R7: indefinite wait
    long_press(3, 16'h1000, 1'b1);
    expect_state("R2 second request", 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) bus_cycle(16'h2000 + 16'(i), 1'b1, 1'b0);
    expect_state("R7 pending persists", 1'b1, 1'b0, 1'b0);

    // R5: run breaks
    bus_cycle(16'h01FF, 1'b0, 1'b0);
    bus_cycle(16'h01FE, 1'b0, 1'b0);
    bus_cycle(16'h01FF, 1'b1, 1'b0);
    bus_cycle(16'h01FD, 1'b0, 1'b0);
    bus_cycle(16'h01FC, 1'b0, 1'b0);
    expect_state("R5 stack read breaks run", 1'b1, 1'b0, 1'b0);
    bus_cycle(16'h0200, 1'b0, 1'b0);
    bus_cycle(16'h01FB, 1'b0, 1'b0);
    bus_cycle(16'h01FA, 1'b0, 1'b0);
    expect_state("R5 off-page write breaks run", 1'b1, 1'b0, 1'b0);
    bus_cycle(16'h01F9, 1'b0, 1'b0);
    expect_state("R5 fresh run of three freezes", 1'b0, 1'b1, 1'b0);

    // R1: reset while pending
    reg_wr(8'h40);
    long_press(3, 16'h1000, 1'b1);
    expect_state("R2 third request", 1'b1, 1'b0, 1'b0);
    pulse_reset();
    expect_state("R1 reset clears pending", 1'b0, 1'b0, 1'b0);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule